// File: doc/BRIEF.md
# Fetch-Block Branch Predictor with Call/Return Stack

This block sits at the front of an instruction fetch pipeline and, for every fetch address, says where the next fetch should go. It combines three structures. The first is a direction table of 2-bit saturating counters, indexed by a global branch history together with a few fetch-address bits. The second is a per-fetch-block target cache that holds two candidate targets and a selector. The third is a small call/return stack that supplies return addresses.

The prediction is combinational from the request address and the stored state. The global history advances speculatively when a conditional-branch block is fetched. The back end trains the tables through an update port and supplies the history value that was in use when the branch was predicted. After a misprediction it can load a corrected history. Calls and returns push and pop the stack directly.

Top module: `fetch_bpred`

## Requirements
- R1: After reset, every direction counter holds 1 (weakly not-taken), every block selector is sequential, the history is 0 and the return stack is empty. As a result, any request predicts not-taken with the sequential address, and one taken update is enough to make a block predict taken.
- R2: The sequential address is the request address with bits [3:0] cleared, plus 16, wrapping modulo 2^32.
- R3: The direction counter is addressed by the 12-bit index {history[7:0], address[7:4]}. Address bits above bit 7 do not affect the index. An update addresses its counter with {upd_hist, upd_addr[7:4]}.
- R4: A counter at 2 or 3 predicts taken. A non-return update increments the counter on taken and decrements it on not-taken, saturating at 3 and at 0.
- R5: The target cache has 16 sets indexed by address[7:4]. Each set holds slot 0, slot 1 and a selector: 00 means sequential, 01 means slot 0, 10 means slot 1 and 11 means return. A taken non-return update does the following. If the target equals slot 0, the selector becomes 01. Otherwise, if it equals slot 1, the selector becomes 10. Otherwise the target is written into slot 1 when the selector is 01, and into slot 0 in every other case, and the selector is pointed at the written slot. Not-taken updates leave the target cache unchanged.
- R6: With selector 01 or 10, the prediction is taken when the counter predicts taken, with the selected slot as the next address; otherwise it is the sequential address. With selector 11, the prediction is taken with the stack top as the next address. If the stack is empty, the prediction is not-taken with the sequential address.
- R7: A valid request to a block whose selector is 01 or 10 shifts the predicted direction into history bit 0. Requests to blocks with selector 00 or 11 leave the history unchanged.
- R8: A history repair loads the supplied value. A repair takes priority over a speculative shift in the same cycle.
- R9: The return stack is last-in first-out with 12 entries. A push onto a full stack discards the oldest entry. A pop from an empty stack has no effect.
- R10: A push and a pop in the same cycle on a non-empty stack replace the top entry and leave the depth unchanged. On an empty stack, the pair acts as a push alone.
- R11: An update flagged as a return sets the block's selector to 11 and leaves the direction counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A fetch is issued this cycle; enables the speculative history shift |
| req_addr | input | 32 | Fetch address |
| pred_taken | output | 1 | Predicted redirect |
| pred_next | output | 32 | Predicted next fetch address |
| pred_hist | output | 8 | Current global history |
| upd_valid | input | 1 | Resolved branch update |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_hist | input | 8 | History used when the branch was predicted |
| upd_taken | input | 1 | Resolved direction |
| upd_is_ret | input | 1 | Resolved branch is a return |
| upd_target | input | 32 | Resolved target |
| call_push | input | 1 | Push a return address |
| call_addr | input | 32 | Return address to push |
| ret_pop | input | 1 | Pop the return stack |
| repair_valid | input | 1 | Load corrected history |
| repair_hist | input | 8 | Corrected history value |

## Verification
A history repair and a speculative history shift can both fall in the same cycle. The bench provokes this by raising repair_valid together with a valid request to a block that holds a conditional target. It then reads pred_hist one cycle later and expects exactly the repaired value, with no shifted bit. A second collision, a push and a pop in the same cycle, is driven on both a non-empty and an empty stack. In each case it is judged through the next address predicted for a block whose selector is 11.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [1:0] {
      SEL_SEQ = 2'b00,
      SEL_T0  = 2'b01,
      SEL_T1  = 2'b10,
      SEL_RET = 2'b11
   } tsel_e;
endpackage

// File: rtl/gs_index.sv
module gs_index #(
   parameter int ADDR_W   = 32,
   parameter int HIST_W   = 8,
   parameter int PC_BITS  = 4,
   parameter int PC_LSB   = 4,
   parameter bit HASH_XOR = 1'b0,
   localparam int IDX_W   = HIST_W + PC_BITS
) (
   input  logic [HIST_W-1:0] hist,
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   logic unused_addr;
   assign unused_addr = ^addr;

   if (PC_LSB + PC_BITS + HIST_W > ADDR_W) begin : g_bad_width
      $error("gs_index: address too narrow for index");
   end

   if (HASH_XOR) begin : g_xor
      assign idx = {hist ^ addr[PC_LSB+PC_BITS +: HIST_W], addr[PC_LSB +: PC_BITS]};
   end else begin : g_cat
      assign idx = {hist, addr[PC_LSB +: PC_BITS]};
   end
endmodule

// File: rtl/gs_dir_table.sv
module gs_dir_table #(
   parameter int IDX_W   = 12,
   localparam int ENTRIES = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   logic [1:0] cnt_q [ENTRIES];
   logic [1:0] wr_cur, wr_nxt;

   if (IDX_W < 2 || IDX_W > 14) begin : g_bad_idx
      $error("gs_dir_table: IDX_W out of range");
   end

   assign rd_taken = cnt_q[rd_idx][1];
   assign wr_cur   = cnt_q[wr_idx];

   always_comb begin
      wr_nxt = wr_cur;
      if (wr_taken && wr_cur != 2'd3)       wr_nxt = wr_cur + 2'd1;
      else if (!wr_taken && wr_cur != 2'd0) wr_nxt = wr_cur - 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= 2'd1;
      end else if (wr_en) begin
         cnt_q[wr_idx] <= wr_nxt;
      end
   end

   AST_CNT_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_taken && wr_cur == 2'd3 |=> cnt_q[$past(wr_idx)] == 2'd3); // R4
   AST_CNT_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_taken && wr_cur == 2'd0 |=> cnt_q[$past(wr_idx)] == 2'd0); // R4
endmodule

// File: rtl/gs_target_cache.sv
module gs_target_cache
   import fbp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SETS    = 16,
   parameter int SET_LSB = 4,
   localparam int SET_W  = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output tsel_e             rd_sel,
   output logic [ADDR_W-1:0] rd_tgt0,
   output logic [ADDR_W-1:0] rd_tgt1,
   input  logic              wr_en,
   input  logic              wr_ret,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] wr_target
);
   tsel_e             sel_q [SETS];
   logic [ADDR_W-1:0] t0_q  [SETS];
   logic [ADDR_W-1:0] t1_q  [SETS];
   logic [SET_W-1:0]  ri, wi;
   logic              unused_addr;

   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("gs_target_cache: SETS must be a power of two");
   end

   assign unused_addr = ^{rd_addr, wr_addr};
   assign ri      = rd_addr[SET_LSB +: SET_W];
   assign wi      = wr_addr[SET_LSB +: SET_W];
   assign rd_sel  = sel_q[ri];
   assign rd_tgt0 = t0_q[ri];
   assign rd_tgt1 = t1_q[ri];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            sel_q[s] <= SEL_SEQ;
            t0_q[s]  <= '0;
            t1_q[s]  <= '0;
         end
      end else if (wr_en) begin
         if (wr_ret) begin
            sel_q[wi] <= SEL_RET;
         end else if (wr_target == t0_q[wi]) begin
            sel_q[wi] <= SEL_T0;
         end else if (wr_target == t1_q[wi]) begin
            sel_q[wi] <= SEL_T1;
         end else if (sel_q[wi] == SEL_T0) begin
            t1_q[wi]  <= wr_target;
            sel_q[wi] <= SEL_T1;
         end else begin
            t0_q[wi]  <= wr_target;
            sel_q[wi] <= SEL_T0;
         end
      end
   end

   AST_TC_TARGET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_ret |=> ((sel_q[$past(wi)] == SEL_T0) ? t0_q[$past(wi)] : t1_q[$past(wi)])
                            == $past(wr_target)); // R5
   AST_TC_RET_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_ret |=> sel_q[$past(wi)] == SEL_RET); // R11
endmodule

// File: rtl/gs_ret_stack.sv
module gs_ret_stack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 12,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_addr,
   output logic [ADDR_W-1:0] top,
   output logic              empty
);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [ADDR_W-1:0] stk_q [DEPTH];
   logic [PTR_W-1:0]  wp_q, wp_inc, top_idx;
   logic [CNT_W-1:0]  cnt_q;
   logic              pop_ok;

   if (DEPTH < 2) begin : g_bad_depth
      $error("gs_ret_stack: DEPTH must be at least 2");
   end

   assign wp_inc  = (wp_q == PTR_LAST) ? '0 : wp_q + PTR_W'(1);
   assign top_idx = (wp_q == '0) ? PTR_LAST : wp_q - PTR_W'(1);
   assign empty   = (cnt_q == '0);
   assign top     = stk_q[top_idx];
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else if (push && pop_ok) begin
         stk_q[top_idx] <= push_addr;
      end else if (push) begin
         stk_q[wp_q] <= push_addr;
         wp_q        <= wp_inc;
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop_ok) begin
         wp_q  <= top_idx;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_RAS_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL); // R9
   AST_RAS_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !empty && top == $past(push_addr)); // R9
   AST_RAS_SWAP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !empty |=> cnt_q == $past(cnt_q)); // R10
endmodule

// File: rtl/fetch_bpred.sv
module fetch_bpred
   import fbp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int HIST_W      = 8,
   parameter int PC_BITS     = 4,
   parameter int BLOCK_BYTES = 16,
   parameter int TC_SETS     = 16,
   parameter int RAS_DEPTH   = 12,
   parameter bit HASH_XOR    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_next,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              upd_taken,
   input  logic              upd_is_ret,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              call_push,
   input  logic [ADDR_W-1:0] call_addr,
   input  logic              ret_pop,
   input  logic              repair_valid,
   input  logic [HIST_W-1:0] repair_hist
);
   localparam int BLK_LSB = $clog2(BLOCK_BYTES);
   localparam int BLK_W   = ADDR_W - BLK_LSB;
   localparam int IDX_W   = HIST_W + PC_BITS;

   if (HIST_W < 2 || BLOCK_BYTES < 2 || (1 << BLK_LSB) != BLOCK_BYTES) begin : g_bad_cfg
      $error("fetch_bpred: illegal history or block size");
   end

   logic [HIST_W-1:0] hist_q;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic              dir_taken;
   tsel_e             blk_sel;
   logic [ADDR_W-1:0] tgt0, tgt1, ras_top, seq_addr;
   logic              ras_empty, blk_cond;
   logic [BLK_W-1:0]  blk_next;

   gs_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS),
              .PC_LSB(BLK_LSB), .HASH_XOR(HASH_XOR)) u_rd_idx (
      .hist(hist_q), .addr(req_addr), .idx(rd_idx));

   gs_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS),
              .PC_LSB(BLK_LSB), .HASH_XOR(HASH_XOR)) u_wr_idx (
      .hist(upd_hist), .addr(upd_addr), .idx(wr_idx));

   gs_dir_table #(.IDX_W(IDX_W)) u_dir (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_taken(dir_taken),
      .wr_en(upd_valid && !upd_is_ret), .wr_idx(wr_idx), .wr_taken(upd_taken));

   gs_target_cache #(.ADDR_W(ADDR_W), .SETS(TC_SETS), .SET_LSB(BLK_LSB)) u_tc (
      .clk(clk), .rst_n(rst_n), .rd_addr(req_addr), .rd_sel(blk_sel),
      .rd_tgt0(tgt0), .rd_tgt1(tgt1),
      .wr_en(upd_valid && (upd_is_ret || upd_taken)), .wr_ret(upd_is_ret),
      .wr_addr(upd_addr), .wr_target(upd_target));

   gs_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk(clk), .rst_n(rst_n), .push(call_push), .pop(ret_pop),
      .push_addr(call_addr), .top(ras_top), .empty(ras_empty));

   assign blk_next = req_addr[ADDR_W-1:BLK_LSB] + BLK_W'(1);
   assign seq_addr = {blk_next, {BLK_LSB{1'b0}}};
   assign blk_cond = (blk_sel == SEL_T0) || (blk_sel == SEL_T1);

   always_comb begin
      pred_taken = 1'b0;
      pred_next  = seq_addr;
      unique case (blk_sel)
         SEL_T0: if (dir_taken) begin pred_taken = 1'b1; pred_next = tgt0; end
         SEL_T1: if (dir_taken) begin pred_taken = 1'b1; pred_next = tgt1; end
         SEL_RET: if (!ras_empty) begin pred_taken = 1'b1; pred_next = ras_top; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      hist_q <= '0;
      else if (repair_valid)           hist_q <= repair_hist;
      else if (req_valid && blk_cond)  hist_q <= {hist_q[HIST_W-2:0], dir_taken};
   end

   assign pred_hist = hist_q;

   AST_REPAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      repair_valid |=> pred_hist == $past(repair_hist)); // R8
   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !repair_valid && (!req_valid || !blk_cond) |=> $stable(pred_hist)); // R7
   AST_RET_EMPTY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      blk_sel == SEL_RET && ras_empty |-> !pred_taken && pred_next == seq_addr); // R6
endmodule

// File: tb/fetch_bpred_test.sv
module fetch_bpred_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        pred_taken;
   logic [31:0] pred_next;
   logic [7:0]  pred_hist;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_addr = '0;
   logic [7:0]  upd_hist = '0;
   logic        upd_taken = 1'b0;
   logic        upd_is_ret = 1'b0;
   logic [31:0] upd_target = '0;
   logic        call_push = 1'b0;
   logic [31:0] call_addr = '0;
   logic        ret_pop = 1'b0;
   logic        repair_valid = 1'b0;
   logic [7:0]  repair_hist = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   localparam logic [31:0] BLK_A = 32'h0000_1040;
   localparam logic [31:0] BLK_B = 32'h0000_1050;
   localparam logic [31:0] BLK_C = 32'h0000_0380;
   localparam logic [31:0] BLK_D = 32'h0000_0A60;

   fetch_bpred uut (.*);

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic upd(input logic [31:0] a, input logic [7:0] h, input logic t,
                      input logic r, input logic [31:0] tg);
      upd_valid = 1'b1; upd_addr = a; upd_hist = h;
      upd_taken = t; upd_is_ret = r; upd_target = tg;
      tick();
      upd_valid = 1'b0; upd_is_ret = 1'b0;
   endtask

   task automatic repair(input logic [7:0] h);
      repair_valid = 1'b1; repair_hist = h;
      tick();
      repair_valid = 1'b0;
   endtask

   task automatic fetch(input logic [31:0] a);
      req_valid = 1'b1; req_addr = a;
      tick();
      req_valid = 1'b0;
   endtask

   task automatic stack_op(input logic ps, input logic pp, input logic [31:0] a);
      call_push = ps; ret_pop = pp; call_addr = a;
      tick();
      call_push = 1'b0; ret_pop = 1'b0;
   endtask

   task automatic peek(input string tag, input logic [31:0] a,
                       input logic et, input logic [31:0] en);
      req_addr = a;
      #1;
      chk({tag, " taken"}, {31'd0, pred_taken}, {31'd0, et});
      chk({tag, " next"}, pred_next, en);
   endtask

   task automatic t_reset();
      chk("R1 history at reset", {24'd0, pred_hist}, 32'd0);
      peek("R1 R2 reset block", 32'h1234_5678, 1'b0, 32'h1234_5680);
      peek("R2 wrap", 32'hFFFF_FFF4, 1'b0, 32'h0000_0000);
      peek("R1 reset selector", BLK_D, 1'b0, 32'h0000_0A70);
   endtask

   task automatic t_dir();
      upd(BLK_A, 8'h00, 1'b1, 1'b0, 32'h2000);
      peek("R1 R5 one taken update", BLK_A, 1'b1, 32'h2000);
      repeat (3) upd(BLK_A, 8'h00, 1'b0, 1'b0, 32'h0);
      peek("R4 floor", BLK_A, 1'b0, 32'h1050);
      upd(BLK_A, 8'h00, 1'b1, 1'b0, 32'h2000);
      peek("R4 saturated at 0", BLK_A, 1'b0, 32'h1050);
      upd(BLK_A, 8'h00, 1'b1, 1'b0, 32'h2000);
      peek("R4 reaches 2", BLK_A, 1'b1, 32'h2000);
      repeat (3) upd(BLK_A, 8'h00, 1'b1, 1'b0, 32'h2000);
      upd(BLK_A, 8'h00, 1'b0, 1'b0, 32'h0);
      peek("R4 saturated at 3", BLK_A, 1'b1, 32'h2000);
      upd(BLK_A, 8'h00, 1'b0, 1'b0, 32'h0);
      peek("R4 back to 1", BLK_A, 1'b0, 32'h1050);
   endtask

   task automatic t_index();
      repair(8'h5A);
      upd(BLK_A, 8'h5A, 1'b1, 1'b0, 32'h2000);
      upd(BLK_A, 8'h5A, 1'b1, 1'b0, 32'h2000);
      peek("R3 history 5A", BLK_A, 1'b1, 32'h2000);
      peek("R3 upper bits ignored", 32'h0000_7F48, 1'b1, 32'h2000);
      repair(8'h00);
      peek("R3 history 00", BLK_A, 1'b0, 32'h1050);
   endtask

   task automatic t_slots();
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h4000);
      peek("R5 slot0 fill", BLK_C, 1'b1, 32'h4000);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h5000);
      peek("R5 slot1 fill", BLK_C, 1'b1, 32'h5000);
      upd(BLK_C, 8'h00, 1'b0, 1'b0, 32'h9999);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h5000);
      peek("R5 not-taken leaves slots", BLK_C, 1'b1, 32'h5000);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h4000);
      peek("R5 match slot0", BLK_C, 1'b1, 32'h4000);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h6000);
      peek("R5 replace slot1", BLK_C, 1'b1, 32'h6000);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h7000);
      peek("R5 replace slot0", BLK_C, 1'b1, 32'h7000);
      upd(BLK_C, 8'h00, 1'b1, 1'b0, 32'h6000);
      peek("R5 old slot1 kept", BLK_C, 1'b1, 32'h6000);
   endtask

   task automatic t_hist();
      repair(8'h00);
      fetch(BLK_C);
      chk("R7 shift taken", {24'd0, pred_hist}, 32'h01);
      fetch(BLK_C);
      chk("R7 shift not-taken", {24'd0, pred_hist}, 32'h02);
      fetch(BLK_A);
      chk("R7 shift other block", {24'd0, pred_hist}, 32'h04);
      fetch(BLK_B);
      chk("R7 sequential block holds", {24'd0, pred_hist}, 32'h04);
      repair_valid = 1'b1; repair_hist = 8'hA5;
      fetch(BLK_C);
      repair_valid = 1'b0;
      chk("R8 repair beats shift", {24'd0, pred_hist}, 32'hA5);
      repair(8'h3C);
      chk("R8 plain repair", {24'd0, pred_hist}, 32'h3C);
   endtask

   task automatic t_ras();
      repair(8'h00);
      upd(BLK_D, 8'h00, 1'b1, 1'b1, 32'h0);
      peek("R6 empty stack", BLK_D, 1'b0, 32'h0000_0A70);
      stack_op(1'b1, 1'b0, 32'h100);
      peek("R6 stack top", BLK_D, 1'b1, 32'h100);
      stack_op(1'b1, 1'b0, 32'h200);
      peek("R9 lifo push", BLK_D, 1'b1, 32'h200);
      stack_op(1'b0, 1'b1, 32'h0);
      peek("R9 lifo pop", BLK_D, 1'b1, 32'h100);
      stack_op(1'b1, 1'b1, 32'h300);
      peek("R10 swap top", BLK_D, 1'b1, 32'h300);
      stack_op(1'b0, 1'b1, 32'h0);
      peek("R10 depth kept", BLK_D, 1'b0, 32'h0000_0A70);
      stack_op(1'b0, 1'b1, 32'h0);
      peek("R9 pop empty", BLK_D, 1'b0, 32'h0000_0A70);
      stack_op(1'b1, 1'b1, 32'h400);
      peek("R10 empty pair pushes", BLK_D, 1'b1, 32'h400);
      stack_op(1'b0, 1'b1, 32'h0);
      for (int k = 0; k < 13; k++) stack_op(1'b1, 1'b0, 32'h1000 + 32'(k) * 32'h10);
      for (int i = 0; i < 12; i++) begin
         peek("R9 overflow order", BLK_D, 1'b1, 32'h1000 + 32'(12 - i) * 32'h10);
         stack_op(1'b0, 1'b1, 32'h0);
      end
      peek("R9 oldest dropped", BLK_D, 1'b0, 32'h0000_0A70);
      upd(BLK_D, 8'h00, 1'b1, 1'b0, 32'h800);
      upd(BLK_D, 8'h00, 1'b0, 1'b0, 32'h0);
      peek("R11 return left counter", BLK_D, 1'b0, 32'h0000_0A70);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_dir();
      t_index();
      t_slots();
      t_hist();
      t_ras();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule